// File: doc/BRIEF.md
# Load/Store Address Generator with Register-Block Sequencer

This block works out the memory address for a load or store of a single register, and steps through multi-register transfers one word at a time. A command is presented together with a one-cycle `start` pulse. It carries a base value, an offset taken either from a 12-bit immediate or from a register value, a direction bit, indexing and write-back controls, a byte/word select, a block flag and a 16-bit register mask. The block then raises `mem_valid` for each memory beat. Each beat is held until `mem_ready` completes a handshake.

Single transfers can be pre-indexed, with or without base update, or post-indexed. A post-indexed transfer always updates the base. A plain register-indirect access is a pre-indexed access with an immediate offset of zero. Block transfers work in increment-after order at consecutive word addresses, lowest-numbered register first. After the final beat of a command the block pulses `done` for one cycle. In that same cycle it presents the new base value and a write-back enable. The register file and the data path sit outside the block.

Top module: `lsu_agen`

## Requirements
- R1: A pre-indexed single transfer (`pre_idx`=1) addresses base plus offset when `add_ofs`=1 and base minus offset when `add_ofs`=0. The offset is `reg_ofs` when `ofs_is_reg`=1, otherwise the zero-extended 12-bit `imm_ofs`.
- R2: A post-indexed single transfer (`pre_idx`=0) addresses the unmodified base. It always asserts `wb_en` at completion, with `wb_value` equal to base plus or minus the offset.
- R3: A pre-indexed single transfer asserts `wb_en` at completion only when `wb_req`=1. `wb_value` is then the addressed base-plus/minus-offset value.
- R4: Word accesses (`byte_acc`=0) force `addr[1:0]` to 0 and drive `lane`=4'b1111. Byte accesses keep every address bit and drive `lane` one-hot, with bit `addr[1:0]` set.
- R5: A block transfer (`blk`=1) issues one beat per set bit of `reg_mask`, in ascending register order. Beat k addresses the word-aligned base plus 4·k, with `lane`=4'b1111 and `reg_idx` equal to the register number. For single transfers `reg_idx` equals `xfer_reg`.
- R6: At the end of a block transfer, `wb_value` equals base plus 4 times the number of set mask bits, and `wb_en` equals `wb_req`. `wb_en` is only ever high together with `done`.
- R7: A block command with an all-zero mask makes no memory beat and raises `done` in the cycle after `start`. `wb_en` follows `wb_req`, and `wb_value` equals base.
- R8: While `mem_valid` is high and `mem_ready` is low, `addr`, `lane` and `reg_idx` hold steady. `done` rises in the cycle after the final handshake. A `start` pulse that arrives while `busy` is high is ignored.
- R9: After reset, `mem_valid`, `done`, `wb_en` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, accepted when not busy |
| busy | output | 1 | Command in progress |
| base | input | 32 | Base register value |
| imm_ofs | input | 12 | Immediate offset magnitude |
| reg_ofs | input | 32 | Register offset value |
| ofs_is_reg | input | 1 | 1 selects the register offset |
| add_ofs | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_idx | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req | input | 1 | Base write-back request |
| byte_acc | input | 1 | 1 byte access, 0 word access |
| blk | input | 1 | 1 selects a multi-register block transfer |
| reg_mask | input | 16 | Register set of a block transfer |
| xfer_reg | input | 4 | Register number of a single transfer |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| addr | output | 32 | Beat address |
| lane | output | 4 | Byte-lane select |
| reg_idx | output | 4 | Register moved by the current beat |
| wb_en | output | 1 | Base write-back enable, valid with done |
| wb_value | output | 32 | New base value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first beat of a command appears one cycle after the clock edge that takes `start`. Each later beat appears in the cycle after the previous handshake. `done`, `wb_en` and `wb_value` appear exactly one cycle after the final handshake, or one cycle after `start` when the mask is empty. The bench records the cycle number of each handshake and of each empty-mask start, and it requires `done` at that cycle plus one, never earlier or later. `mem_ready` drops every third cycle, so beats are compared only at real handshakes, while a checker watches that stalled beats stay steady.

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  input  logic [AW-1:0]   base,
  input  logic [IMMW-1:0] imm_ofs,
  input  logic [AW-1:0]   reg_ofs,
  input  logic            ofs_is_reg,
  input  logic            add_ofs,
  input  logic            pre_idx,
  input  logic            wb_req,
  input  logic            byte_acc,
  input  logic            blk,
  input  logic [NREG-1:0] reg_mask,
  input  logic [IW-1:0]   xfer_reg,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   addr,
  output logic [3:0]      lane,
  output logic [IW-1:0]   reg_idx,
  output logic            wb_en,
  output logic [AW-1:0]   wb_value,
  output logic            done
);

  logic [AW-1:0]   ofs, moved, pick, addr_q, wbv_q;
  logic [3:0]      lane_q;
  logic [IW-1:0]   rd_q, low_idx;
  logic [NREG-1:0] rem_q;
  logic [CW-1:0]   cnt;
  logic            blk_q, wbe_q, busy_q, done_q, wben_q;
  logic            hs, last, accept, empty_blk;

  assign ofs       = ofs_is_reg ? reg_ofs : AW'(imm_ofs);
  assign moved     = add_ofs ? base + ofs : base - ofs;
  assign pick      = pre_idx ? moved : base;
  assign accept    = start & ~busy_q;
  assign empty_blk = reg_mask == '0;
  assign hs        = busy_q & mem_ready;
  assign last      = ~blk_q | ((rem_q & (rem_q - 1'b1)) == '0);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(reg_mask[i]);
  end

  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem_q[i]) low_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wben_q <= 1'b0;
      blk_q  <= 1'b0;
      wbe_q  <= 1'b0;
      addr_q <= '0;
      wbv_q  <= '0;
      lane_q <= '0;
      rd_q   <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      wben_q <= 1'b0;
      if (accept) begin
        blk_q <= blk;
        rd_q  <= xfer_reg;
        rem_q <= reg_mask;
        if (blk) begin
          addr_q <= {base[AW-1:2], 2'b00};
          lane_q <= 4'hF;
          wbv_q  <= base + (AW'(cnt) << 2);
          wbe_q  <= wb_req;
          busy_q <= ~empty_blk;
          done_q <= empty_blk;
          wben_q <= empty_blk & wb_req;
        end else begin
          addr_q <= byte_acc ? pick : {pick[AW-1:2], 2'b00};
          lane_q <= byte_acc ? (4'b0001 << pick[1:0]) : 4'hF;
          wbv_q  <= moved;
          wbe_q  <= wb_req | ~pre_idx;
          busy_q <= 1'b1;
        end
      end else if (hs) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          wben_q <= wbe_q;
        end else begin
          addr_q <= addr_q + AW'(4);
          rem_q  <= rem_q & (rem_q - 1'b1);
        end
      end
    end
  end

  assign busy      = busy_q;
  assign mem_valid = busy_q;
  assign addr      = addr_q;
  assign lane      = lane_q;
  assign reg_idx   = blk_q ? low_idx : rd_q;
  assign wb_en     = wben_q;
  assign wb_value  = wbv_q;
  assign done      = done_q;

endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] addr,
  input logic [3:0]    lane,
  input logic [IW-1:0] reg_idx,
  input logic          wb_en,
  input logic          done
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(addr) && $stable(lane) && $stable(reg_idx)); // R8

  AST_LAUNCH_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(start)); // R8

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && lane == 4'hF |-> addr[1:0] == 2'b00); // R4

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && lane != 4'hF |-> $countones(lane) == 1 && lane[addr[1:0]]); // R4

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid); // R7

endmodule

bind lsu_agen lsu_agen_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .addr(addr), .lane(lane), .reg_idx(reg_idx),
  .wb_en(wb_en), .done(done)
);

// File: tb/lsu_agen_tb.sv
module lsu_agen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy;
  logic [31:0] base = '0;
  logic [11:0] imm_ofs = '0;
  logic [31:0] reg_ofs = '0;
  logic        ofs_is_reg = 1'b0, add_ofs = 1'b0, pre_idx = 1'b0, wb_req = 1'b0;
  logic        byte_acc = 1'b0, blk = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [3:0]  xfer_reg = '0;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] addr, wb_value;
  logic [3:0]  lane, reg_idx;
  logic        wb_en, done;

  int checks = 0, fails = 0, cyc = 0, exp_done = -1;
  string cur_tag = "";
  logic [39:0] beat_q[$];
  logic [32:0] end_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  lsu_agen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .base(base),
    .imm_ofs(imm_ofs), .reg_ofs(reg_ofs), .ofs_is_reg(ofs_is_reg),
    .add_ofs(add_ofs), .pre_idx(pre_idx), .wb_req(wb_req), .byte_acc(byte_acc),
    .blk(blk), .reg_mask(reg_mask), .xfer_reg(xfer_reg), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .addr(addr), .lane(lane), .reg_idx(reg_idx),
    .wb_en(wb_en), .wb_value(wb_value), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(posedge clk); #1;
    mem_ready = (cyc % 3) != 0;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_valid && mem_ready) begin
      if (beat_q.size() == 0) begin
        check({"R8 unexpected beat ", cur_tag}, 64'(addr), 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        logic [39:0] e;
        e = beat_q.pop_front();
        check({cur_tag, " beat addr/lane/idx"}, 64'({addr, lane, reg_idx}), 64'(e));
        if (beat_q.size() == 0) exp_done = cyc + 1;
      end
    end
    if (done) begin
      check({"R8 done cycle ", cur_tag}, 64'(cyc), 64'(exp_done));
      if (end_q.size() == 0) begin
        check({"R8 unexpected done ", cur_tag}, 64'(1), 64'(0));
      end else begin
        logic [32:0] e;
        e = end_q.pop_front();
        check({cur_tag, " wb_en"}, 64'(wb_en), 64'(e[32]));
        if (e[32]) check({cur_tag, " wb_value"}, 64'(wb_value), 64'(e[31:0]));
      end
    end
  end

  task automatic issue(input string tag, input logic [31:0] b, input logic [11:0] imm,
                       input logic [31:0] rofs, input logic isreg, input logic up,
                       input logic pre, input logic wb, input logic byt, input logic bk,
                       input logic [15:0] mask, input logic [3:0] rd, input bit rogue);
    cur_tag = tag;
    if (bk) begin
      int k = 0;
      for (int i = 0; i < 16; i++)
        if (mask[i]) begin
          beat_q.push_back({{b[31:2], 2'b00} + 32'(4 * k), 4'hF, 4'(i)});
          k++;
        end
      end_q.push_back({wb, b + 32'(4 * k)});
    end else begin
      logic [31:0] o, m, p;
      o = isreg ? rofs : {20'b0, imm};
      m = up ? b + o : b - o;
      p = pre ? m : b;
      beat_q.push_back({byt ? p : {p[31:2], 2'b00}, byt ? (4'b0001 << p[1:0]) : 4'hF, rd});
      end_q.push_back({wb | ~pre, m});
    end
    @(posedge clk); #1;
    base = b; imm_ofs = imm; reg_ofs = rofs; ofs_is_reg = isreg; add_ofs = up;
    pre_idx = pre; wb_req = wb; byte_acc = byt; blk = bk; reg_mask = mask; xfer_reg = rd;
    start = 1'b1;
    if (bk && mask == '0) exp_done = cyc + 1;
    @(posedge clk); #1;
    start = 1'b0;
    if (rogue) begin
      @(posedge clk); #1;
      base = 32'hDEAD_0000; blk = 1'b0; pre_idx = 1'b0; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    wait (end_q.size() == 0);
    repeat (4) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset mem_valid", 64'(mem_valid), 64'(0));
    check("R9 reset done", 64'(done), 64'(0));
    check("R9 reset wb_en", 64'(wb_en), 64'(0));
    check("R9 reset busy", 64'(busy), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    issue("R1/R3 pre imm up word", 32'h0000_1000, 12'h010, 32'h0, 0, 1, 1, 0, 0, 0, 16'h0, 4'd3, 0);
    issue("R1/R3/R4 pre reg down byte wb", 32'h0000_2003, 12'h0, 32'h5, 1, 0, 1, 1, 1, 0, 16'h0, 4'd7, 0);
    issue("R2/R4 post imm up byte", 32'h0000_3001, 12'hFFF, 32'h0, 0, 1, 0, 0, 1, 0, 16'h0, 4'd1, 0);
    issue("R2/R4 post reg down word", 32'h0000_5006, 12'h0, 32'h4, 1, 0, 0, 0, 0, 0, 16'h0, 4'd9, 0);
    issue("R1 indirect word", 32'h0000_0102, 12'h0, 32'h0, 0, 1, 1, 1, 0, 0, 16'h0, 4'd0, 0);
    issue("R5/R6 block sparse wb", 32'h0000_8000, 12'h0, 32'h0, 0, 1, 1, 1, 0, 1, 16'h8025, 4'd0, 0);
    issue("R5/R6 block full no wb", 32'h0000_0012, 12'h0, 32'h0, 0, 1, 1, 0, 0, 1, 16'hFFFF, 4'd0, 0);
    issue("R7 empty mask wb", 32'h0000_0040, 12'h0, 32'h0, 0, 1, 1, 1, 0, 1, 16'h0000, 4'd0, 0);
    issue("R7 empty mask no wb", 32'h0000_0044, 12'h0, 32'h0, 0, 1, 1, 0, 0, 1, 16'h0000, 4'd0, 0);
    issue("R8 start while busy", 32'h0000_0200, 12'h0, 32'h0, 0, 1, 1, 1, 0, 1, 16'h0003, 4'd0, 1);
    issue("R5 single bit high", 32'h0000_0300, 12'h0, 32'h0, 0, 1, 1, 1, 0, 1, 16'h4000, 4'd0, 0);

    repeat (6) @(posedge clk);
    check("R8 leftover items", 64'(beat_q.size() + end_q.size()), 64'(0));
    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

endmodule